// File: doc/BRIEF.md
# Vectored Two-Level Interrupt Controller

This block collects 32 interrupt sources and presents them to a processor as two request lines. Each source is set by software to edge or level sensitivity. Pending status is held in a status register and masked by an enable register. A per-bit critical-select register then routes every enabled pending source to either the normal request output or the critical request output.

For the critical class, the block also computes a vector address. This address is the upper bits of a vector-config register plus 512 times the position of the highest-priority pending critical source. Bit 0 of vector-config chooses which end of the status word has priority.

Software reaches the block through a small register port. The port has a 4-bit register offset, a read strobe, a write strobe, 32-bit write data and registered 32-bit read data. Vector support can be removed with a parameter.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the status, enable, critical-select, polarity, trigger-type, vector-config and vector registers are all zero, and both request outputs and the read data are low.
- R2: Input n (irq_src[n]) drives status bit 31-n.
- R3: A source whose trigger-type bit is 1 is edge sensitive. A rising edge of its input, detected against a one-cycle delayed copy, sets its status bit. The bit stays set after the input falls until software clears it.
- R4: A source whose trigger-type bit is 0 is level sensitive. When its input changes, its status bit and a hidden hold bit both take the new input value.
- R5: A write to offset 0 clears each status bit written as 1. The hold bits of high level sources are then ORed back in, so those bits stay set.
- R6: A write to offset 1 ORs the written value into status. A read of offset 1 returns status, as does a read of offset 0.
- R7: One cycle after the state changes, irq_normal is the OR of (status & enable & ~critical) and irq_critical is the OR of (status & enable & critical). Offsets: 2 is enable and 3 is critical-select.
- R8: A read of offset 6 returns status & enable. Writes to offsets 6 and 7 have no effect. Offsets 9 to 15 read as zero. Read data appears one cycle after the read strobe, and is zero in cycles with no read.
- R9: Offset 8 holds vector-config. With bit 0 clear, the vector is (vector-config & ~3) + i*512, where i is the lowest set bit of status & enable & critical.
- R10: With vector-config bit 0 set, the vector is (vector-config & ~3) + (31-i)*512, where i is the highest set bit of status & enable & critical.
- R11: Bit 1 of vector-config always reads as zero. The vector (offset 7 and crit_vector) is zero whenever no critical source is pending.
- R12: With HAS_VECTOR = 0, offsets 7 and 8 read as zero and crit_vector stays zero.
- R13: Offset 4 (polarity) stores and returns the written value and has no effect on how inputs are sensed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Interrupt source inputs, already synchronous |
| reg_ofs | input | OFS_W | Register offset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| irq_normal | output | 1 | Normal-class request |
| irq_critical | output | 1 | Critical-class request |
| crit_vector | output | 32 | Critical vector address |

## Verification
A register write, or an input change sampled at an edge, updates status and the other registers at that edge. The request outputs and the vector follow one edge later, so they lag an input change by two edges. Read data is registered at the edge where rd_en is sampled and shows the state from before any write in that same cycle. The bench model applies these same latencies. Directed steps therefore insert an idle cycle before they look at the outputs or the vector, and the random phase compares every output against the model on each falling edge.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter bit HAS_VECTOR = 1'b1,
  parameter int VEC_SHIFT  = 9,
  parameter int OFS_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      irq_src,
  input  logic [OFS_W-1:0] reg_ofs,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             irq_normal,
  output logic             irq_critical,
  output logic [31:0]      crit_vector
);

  localparam int NSRC = 32;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] status, level_hold, enable, crit_sel, polarity, trig_edge;
  logic [31:0]     vcfg;
  logic [NSRC-1:0] src_now, src_prev;
  logic [NSRC-1:0] status_nx, hold_nx;
  logic [NSRC-1:0] crit_pend, scan_word;
  logic [IDX_W-1:0] first_idx;
  logic [31:0]     vec_nx, rd_mux;

  for (genvar b = 0; b < NSRC; b++) begin : g_map
    assign src_now[b] = irq_src[NSRC-1-b];
  end

  wire wr_clr = wr_en && reg_ofs == OFS_W'(0);
  wire wr_set = wr_en && reg_ofs == OFS_W'(1);

  always_comb begin
    status_nx = status;
    hold_nx   = level_hold;
    if (wr_clr) status_nx = (status_nx & ~wr_data) | level_hold;
    if (wr_set) status_nx = status_nx | wr_data;
    for (int b = 0; b < NSRC; b++) begin
      if (trig_edge[b]) begin
        if (src_now[b] && !src_prev[b]) status_nx[b] = 1'b1;
      end else if (src_now[b] != src_prev[b]) begin
        status_nx[b] = src_now[b];
        hold_nx[b]   = src_now[b];
      end
    end
  end

  assign crit_pend = status & enable & crit_sel;

  for (genvar b = 0; b < NSRC; b++) begin : g_scan
    assign scan_word[b] = vcfg[0] ? crit_pend[NSRC-1-b] : crit_pend[b];
  end

  always_comb begin
    first_idx = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (scan_word[i]) first_idx = IDX_W'(i);
  end

  assign vec_nx = (HAS_VECTOR && |crit_pend)
                ? {vcfg[31:2], 2'b00} + (32'(first_idx) << VEC_SHIFT) : 32'h0;

  always_comb begin
    case (reg_ofs)
      OFS_W'(0), OFS_W'(1): rd_mux = status;
      OFS_W'(2): rd_mux = enable;
      OFS_W'(3): rd_mux = crit_sel;
      OFS_W'(4): rd_mux = polarity;
      OFS_W'(5): rd_mux = trig_edge;
      OFS_W'(6): rd_mux = status & enable;
      OFS_W'(7): rd_mux = HAS_VECTOR ? crit_vector : 32'h0;
      OFS_W'(8): rd_mux = HAS_VECTOR ? vcfg : 32'h0;
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status       <= '0;
      level_hold   <= '0;
      enable       <= '0;
      crit_sel     <= '0;
      polarity     <= '0;
      trig_edge    <= '0;
      vcfg         <= '0;
      src_prev     <= '0;
      rd_data      <= '0;
      irq_normal   <= 1'b0;
      irq_critical <= 1'b0;
      crit_vector  <= '0;
    end else begin
      status     <= status_nx;
      level_hold <= hold_nx;
      src_prev   <= src_now;
      if (wr_en) begin
        case (reg_ofs)
          OFS_W'(2): enable    <= wr_data;
          OFS_W'(3): crit_sel  <= wr_data;
          OFS_W'(4): polarity  <= wr_data;
          OFS_W'(5): trig_edge <= wr_data;
          OFS_W'(8): if (HAS_VECTOR) vcfg <= wr_data & ~32'h2;
          default: ;
        endcase
      end
      rd_data      <= rd_en ? rd_mux : 32'h0;
      irq_normal   <= |(status & enable & ~crit_sel);
      irq_critical <= |crit_pend;
      crit_vector  <= vec_nx;
    end
  end

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int OFS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OFS_W-1:0] reg_ofs,
  input logic             rd_en,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             irq_normal,
  input logic             irq_critical,
  input logic [31:0]      crit_vector,
  input logic [31:0]      status,
  input logic [31:0]      enable,
  input logic [31:0]      crit_sel,
  input logic [31:0]      trig_edge,
  input logic [31:0]      vcfg
);

  logic [31:0] edge_keep;
  assign edge_keep = status & trig_edge &
                     ~((wr_en && reg_ofs == OFS_W'(0)) ? wr_data : 32'h0);

  p_normal_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_normal == $past(|(status & enable & ~crit_sel)));

  p_critical_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_critical == $past(|(status & enable & crit_sel)));

  p_vec_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_critical |-> crit_vector == 32'h0);

  p_vcfg_bit1_r11: assert property (@(posedge clk) disable iff (!rst_n)
    vcfg[1] == 1'b0);

  p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status & $past(edge_keep)) == $past(edge_keep));

  p_masked_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_ofs == OFS_W'(6)) |=> rd_data == $past(status & enable));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_ofs(reg_ofs), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .irq_normal(irq_normal),
  .irq_critical(irq_critical), .crit_vector(crit_vector), .status(status),
  .enable(enable), .crit_sel(crit_sel), .trig_edge(trig_edge), .vcfg(vcfg)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [3:0]  reg_ofs = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, crit_vector, nv_rd_data, nv_vector;
  logic        irq_normal, irq_critical, nv_normal, nv_critical;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_ofs(reg_ofs),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_normal(irq_normal), .irq_critical(irq_critical), .crit_vector(crit_vector));

  irq_vector_ctrl #(.HAS_VECTOR(1'b0)) u_novec (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_ofs(reg_ofs),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(nv_rd_data),
    .irq_normal(nv_normal), .irq_critical(nv_critical), .crit_vector(nv_vector));

  // reference model built from the requirements
  logic [31:0] m_st, m_hold, m_en, m_cr, m_pol, m_trig, m_vcr, m_prev, m_rd, m_vec;
  logic        m_norm, m_crit;

  function automatic logic [31:0] vec_of(logic [31:0] st, en, cr, vcr);
    logic [31:0] cp = st & en & cr;
    logic [31:0] v = 32'h0;
    if (cp != 0) begin
      if (!vcr[0]) begin
        for (int i = 31; i >= 0; i--) if (cp[i]) v = (vcr & ~32'h3) + 32'(i) * 512;
      end else begin
        for (int i = 0; i < 32; i++) if (cp[i]) v = (vcr & ~32'h3) + 32'(31 - i) * 512;
      end
    end
    return v;
  endfunction

  function automatic logic [31:0] read_of(logic [3:0] o);
    case (o)
      0, 1: return m_st;
      2: return m_en;
      3: return m_cr;
      4: return m_pol;
      5: return m_trig;
      6: return m_st & m_en;
      7: return m_vec;
      8: return m_vcr;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [31:0] s, h;
    if (!rst_n) begin
      m_st <= 0; m_hold <= 0; m_en <= 0; m_cr <= 0; m_pol <= 0; m_trig <= 0;
      m_vcr <= 0; m_prev <= 0; m_rd <= 0; m_vec <= 0; m_norm <= 0; m_crit <= 0;
    end else begin
      s = m_st; h = m_hold;
      if (wr_en && reg_ofs == 0) s = (s & ~wr_data) | m_hold;
      if (wr_en && reg_ofs == 1) s = s | wr_data;
      for (int n = 0; n < 32; n++) begin
        if (m_trig[31-n]) begin
          if (irq_src[n] && !m_prev[n]) s[31-n] = 1'b1;
        end else if (irq_src[n] != m_prev[n]) begin
          s[31-n] = irq_src[n]; h[31-n] = irq_src[n];
        end
      end
      m_rd <= rd_en ? read_of(reg_ofs) : 32'h0;
      m_norm <= |(m_st & m_en & ~m_cr);
      m_crit <= |(m_st & m_en & m_cr);
      m_vec <= vec_of(m_st, m_en, m_cr, m_vcr);
      m_st <= s; m_hold <= h; m_prev <= irq_src;
      if (wr_en) case (reg_ofs)
        2: m_en <= wr_data;
        3: m_cr <= wr_data;
        4: m_pol <= wr_data;
        5: m_trig <= wr_data;
        8: m_vcr <= wr_data & ~32'h2;
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] o, logic [31:0] d);
    reg_ofs = o; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] o, output logic [31:0] d, output logic [31:0] nv);
    reg_ofs = o; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; nv = nv_rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_src = '0; wr_en = 0; rd_en = 0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, nv;
    do_reset();
    // R1 reset state
    chk("R1 irq_normal", 32'(irq_normal), 0);
    chk("R1 irq_critical", 32'(irq_critical), 0);
    chk("R1 rd_data", rd_data, 0);
    for (int o = 0; o <= 8; o++) begin
      rd(4'(o), d, nv);
      chk($sformatf("R1 reg %0d", o), d, 0);
    end
    // R13 polarity is storage only
    wr(4, 32'hFFFF_FFFF);
    rd(4, d, nv); chk("R13 polarity readback", d, 32'hFFFF_FFFF);
    tick(1);
    rd(0, d, nv); chk("R13 no inversion", d, 0);
    // R3 edge, R2 mapping
    wr(5, 32'hFFFF_FFFF);
    irq_src[3] = 1'b1; tick(1);
    rd(0, d, nv); chk("R2 R3 edge sets bit 28", d, 32'h1000_0000);
    irq_src[3] = 1'b0; tick(1);
    rd(0, d, nv); chk("R3 sticky after fall", d, 32'h1000_0000);
    wr(0, 32'h1000_0000);
    rd(0, d, nv); chk("R3 write-one clear", d, 0);
    // R4 R5 level
    wr(5, 32'h0);
    irq_src[5] = 1'b1; tick(1);
    rd(0, d, nv); chk("R4 level sets bit 26", d, 32'h0400_0000);
    wr(0, 32'h0400_0000);
    rd(0, d, nv); chk("R5 held level survives clear", d, 32'h0400_0000);
    irq_src[5] = 1'b0; tick(1);
    rd(0, d, nv); chk("R4 level clears on low", d, 0);
    // R6 R7 R8
    wr(1, 32'h0000_0110);
    rd(1, d, nv); chk("R6 set and offset1 read", d, 32'h0000_0110);
    wr(2, 32'h0000_0100);
    rd(6, d, nv); chk("R8 masked status", d, 32'h0000_0100);
    chk("R7 normal high", 32'(irq_normal), 1);
    chk("R7 critical low", 32'(irq_critical), 0);
    wr(6, 32'hFFFF_FFFF);
    rd(6, d, nv); chk("R8 write to 6 ignored", d, 32'h0000_0100);
    rd(9, d, nv); chk("R8 offset 9 zero", d, 0);
    rd(15, d, nv); chk("R8 offset 15 zero", d, 0);
    // R9 R10 R11 R12 vector
    wr(3, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    wr(8, 32'h1000_0003);
    rd(8, d, nv);
    chk("R11 vcfg bit1 cleared", d, 32'h1000_0001);
    chk("R12 no-vector cfg reads zero", nv, 0);
    tick(1);
    chk("R10 downward vector", crit_vector, 32'h1000_2E00);
    chk("R7 critical high", 32'(irq_critical), 1);
    chk("R7 normal low", 32'(irq_normal), 0);
    chk("R12 no-vector port zero", nv_vector, 0);
    wr(8, 32'h1000_0000); tick(1);
    rd(7, d, nv);
    chk("R9 upward vector", d, 32'h1000_0800);
    chk("R12 no-vector reads zero", nv, 0);
    wr(7, 32'h0); tick(1);
    rd(7, d, nv); chk("R8 write to 7 ignored", d, 32'h1000_0800);
    wr(0, 32'hFFFF_FFFF); tick(1);
    chk("R11 vector zero when idle", crit_vector, 0);
    chk("R11 critical low when idle", 32'(irq_critical), 0);

    // constrained random against the model
    do_reset();
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4000; c++) begin
      chk("R7 random irq_normal", 32'(irq_normal), 32'(m_norm));
      chk("R7 random irq_critical", 32'(irq_critical), 32'(m_crit));
      chk("R9 R10 random vector", crit_vector, m_vec);
      chk("R8 random rd_data", rd_data, m_rd);
      chk("R12 random no-vector", nv_vector, 0);
      irq_src = irq_src ^ ($urandom() & $urandom() & $urandom() & $urandom());
      wr_en = ($urandom() % 4) == 0;
      rd_en = ($urandom() % 2) == 0;
      reg_ofs = ($urandom() % 5 == 0) ? 4'($urandom()) : 4'($urandom() % 9);
      wr_data = ($urandom() % 3 == 0) ? ($urandom() & $urandom()) : $urandom();
      @(negedge clk);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule